// File: doc/BRIEF.md
# Slow Timeout Tick Generator

This block divides the system clock down to a very slow periodic tick. Consumers such as a jack-insertion debouncer and a zero-crossing timeout for volume changes take the tick as their time base. Software starts or stops the divider with one enable bit and selects a fast or a slow period with one rate bit.

The enable bit is mapped at two register addresses. A power-management word holds it at bit 8. A clock-control word holds it at bit 15, with the rate select at bit 14. Both addresses refer to the same stored bit, so a write through either one can be read back at once through the other. The divider's exponents are parameters. By default the slow period is 2^21 cycles and the fast period is 2^19 cycles.

Top module: `slow_tick_gen`

## Requirements
- R1: After reset the enable and rate bits are 0, a read of either address returns 0, and tick stays low.
- R2: While the enable bit is 0, tick never goes high.
- R3: With rate bit 0, the first tick is high in the cycle after the 2^SLOW_SHIFT-th rising edge that follows the enabling write edge. Later ticks repeat every 2^SLOW_SHIFT cycles.
- R4: With rate bit 1, the period is 2^FAST_SHIFT cycles, counted in the same way as in R3.
- R5: Each tick is high for exactly one clock cycle.
- R6: A write to address PWR_ADDR (default 0x0B) sets the enable from data bit 8. The new value reads back in the next cycle at address CLK_ADDR (default 0x28), bit 15.
- R7: A write to CLK_ADDR sets the enable from data bit 15 and the rate from data bit 14. The new enable value reads back at PWR_ADDR bit 8.
- R8: Clearing the enable resets the divider. After the block is enabled again, the first tick comes one full period after the enabling write.
- R9: A write that changes the rate bit restarts the count. The next tick then comes one full new period after that write. A write that leaves the rate unchanged does not disturb the count.
- R10: Writes to any other address have no effect. Reads of any other address return 0, and unused bits in both mapped words read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address for the read and write |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Combinational read data for regAddr |
| tick | output | 1 | One-cycle slow tick |

## Verification
The conditions hardest to reach from the ports are a rate change and a disable–enable cycle in the middle of a period. From outside, both look like a tick that simply arrives later. The bench therefore runs the divider for part of a period, then rewrites the rate, or clears and sets the enable through the alias address. It then counts edges from that write and expects one full new period with no earlier tick. A rewrite that keeps the same rate is also issued mid-period, and the bench checks that the original tick time is unchanged. Small exponent values keep each period short.

// File: rtl/slow_tick_pkg.sv
package slow_tick_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic runEn;    // divider allowed to count
    logic fastSel;  // 1 selects the short period
    logic restart;  // one-cycle request to clear the count
  } tickCtrl_t;

  // Bit positions decoded by software
  localparam int PWR_EN_BIT  = 8;
  localparam int CLK_EN_BIT  = 15;
  localparam int CLK_FST_BIT = 14;
endpackage

// File: rtl/slow_tick_ctrl.sv
module slow_tick_ctrl
  import slow_tick_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] PWR_ADDR = 8'h0B,
  parameter logic [ADDR_W-1:0] CLK_ADDR = 8'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output tickCtrl_t         ctrlStrb
);
  logic enBit;
  logic rateBit;
  logic hitPwr;
  logic hitClk;
  logic wrPwr;
  logic wrClk;
  logic nextEn;
  logic nextRate;

  assign hitPwr = (regAddr == PWR_ADDR);
  assign hitClk = (regAddr == CLK_ADDR);
  assign wrPwr  = regWrEn && hitPwr;
  assign wrClk  = regWrEn && hitClk;

  always_comb begin
    nextEn   = enBit;
    nextRate = rateBit;
    if (wrPwr) begin
      nextEn = regWrData[PWR_EN_BIT];
    end else if (wrClk) begin
      nextEn   = regWrData[CLK_EN_BIT];
      nextRate = regWrData[CLK_FST_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enBit   <= 1'b0;
      rateBit <= 1'b0;
    end else begin
      enBit   <= nextEn;
      rateBit <= nextRate;
    end
  end

  always_comb begin
    regRdData = '0;
    if (hitPwr) begin
      regRdData[PWR_EN_BIT] = enBit;
    end else if (hitClk) begin
      regRdData[CLK_EN_BIT]  = enBit;
      regRdData[CLK_FST_BIT] = rateBit;
    end
  end

  always_comb begin
    ctrlStrb.runEn   = enBit;
    ctrlStrb.fastSel = rateBit;
    ctrlStrb.restart = wrClk && (nextRate != rateBit);
  end
endmodule

// File: rtl/slow_tick_dp.sv
module slow_tick_dp
  import slow_tick_pkg::*;
#(
  parameter int SLOW_SHIFT = 21,
  parameter int FAST_SHIFT = 19
) (
  input  logic      clk,
  input  logic      rst,
  input  tickCtrl_t ctrlStrb,
  output logic      tick
);
  localparam int CNT_W = SLOW_SHIFT;
  localparam logic [CNT_W-1:0] SLOW_LAST = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'((64'd1 << FAST_SHIFT) - 64'd1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] termCnt;
  logic             atTerm;
  logic             tickQ;

  generate
    if (FAST_SHIFT == SLOW_SHIFT) begin : g_sameRate
      assign termCnt = SLOW_LAST;
    end else begin : g_twoRate
      assign termCnt = ctrlStrb.fastSel ? FAST_LAST : SLOW_LAST;
    end
  endgenerate

  assign atTerm = (cnt == termCnt);

  always_ff @(posedge clk) begin
    if (rst || !ctrlStrb.runEn || ctrlStrb.restart) begin
      cnt   <= '0;
      tickQ <= 1'b0;
    end else if (atTerm) begin
      cnt   <= '0;
      tickQ <= 1'b1;
    end else begin
      cnt   <= cnt + 1'b1;
      tickQ <= 1'b0;
    end
  end

  assign tick = tickQ;
endmodule

// File: rtl/slow_tick_gen.sv
module slow_tick_gen
  import slow_tick_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] PWR_ADDR = 8'h0B,
  parameter logic [ADDR_W-1:0] CLK_ADDR = 8'h28,
  parameter int SLOW_SHIFT = 21,
  parameter int FAST_SHIFT = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              tick
);
  tickCtrl_t ctrlStrb;

  slow_tick_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PWR_ADDR(PWR_ADDR), .CLK_ADDR(CLK_ADDR)
  ) u_ctrl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .ctrlStrb(ctrlStrb)
  );

  slow_tick_dp #(
    .SLOW_SHIFT(SLOW_SHIFT), .FAST_SHIFT(FAST_SHIFT)
  ) u_dp (
    .clk(clk), .rst(rst), .ctrlStrb(ctrlStrb), .tick(tick)
  );
endmodule

// File: rtl/slow_tick_gen_chk.sv
module slow_tick_gen_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PWR_ADDR = 8'h0B,
  parameter logic [ADDR_W-1:0] CLK_ADDR = 8'h28
) (
  input logic              clk,
  input logic              rst,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              runEn,
  input logic              fastSel,
  input logic              tick
);
  logic mapWr;
  logic clkWr;
  assign mapWr = regWrEn && ((regAddr == PWR_ADDR) || (regAddr == CLK_ADDR));
  assign clkWr = regWrEn && (regAddr == CLK_ADDR);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!runEn && !fastSel && !tick)); // R1
  AST_NO_TICK_OFF: assert property (@(posedge clk) disable iff (rst) tick |-> $past(runEn)); // R2
  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) tick |=> !tick); // R5
  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (rst) !mapWr |=> $stable(runEn)); // R10
  AST_RATE_HOLDS: assert property (@(posedge clk) disable iff (rst) !clkWr |=> $stable(fastSel)); // R9
endmodule

bind slow_tick_gen slow_tick_gen_chk #(
  .ADDR_W(ADDR_W), .PWR_ADDR(PWR_ADDR), .CLK_ADDR(CLK_ADDR)
) chk (
  .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
  .runEn(ctrlStrb.runEn), .fastSel(ctrlStrb.fastSel), .tick(tick)
);

// File: tb/slow_tick_gen_test.sv
`timescale 1ns/1ps
module slow_tick_gen_test;
  localparam int SLOW = 6;
  localparam int FAST = 4;
  localparam int PS = 1 << SLOW;
  localparam int PF = 1 << FAST;
  localparam logic [7:0] A_PWR = 8'h0B;
  localparam logic [7:0] A_CLK = 8'h28;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [15:0] regWrData = 16'h0000;
  logic [15:0] regRdData;
  logic tick;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  slow_tick_gen #(.SLOW_SHIFT(SLOW), .FAST_SHIFT(FAST)) uut (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .tick(tick)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Write issued at a negedge, taken at the next posedge; returns at the negedge after.
  task automatic regWrite(logic [7:0] a, logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0; regAddr = 8'h00; regWrData = 16'h0;
  endtask

  task automatic readCheck(string req, logic [7:0] a, logic [15:0] exp);
    regAddr = a; #0.5;
    check(req, regRdData, exp);
    regAddr = 8'h00;
  endtask

  // Called right after a write; expects the first tick at edge p, then at 2p.
  task automatic expectPeriod(string req, int p);
    int firstAt = 0;
    int secondAt = 0;
    for (int i = 1; i <= 2 * p + 1; i++) begin
      @(posedge clk); @(negedge clk);
      if (tick) begin
        if (firstAt == 0) firstAt = i;
        else if (secondAt == 0) secondAt = i;
      end
    end
    check({req, " first tick edge"}, 16'(firstAt), 16'(p));
    check({req, " second tick edge"}, 16'(secondAt), 16'(2 * p));
  endtask

  task automatic idleNoTick(string req, int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (tick) seen++;
    end
    check(req, 16'(seen), 16'd0);
  endtask

  task automatic testReset();
    readCheck("R1 pwr read", A_PWR, 16'h0000);
    readCheck("R1 clk read", A_CLK, 16'h0000);
    check("R1 tick low", {15'd0, tick}, 16'd0);
    idleNoTick("R2 disabled after reset", PS * 2);
  endtask

  task automatic testSlow();
    regWrite(A_PWR, 16'h0100);
    expectPeriod("R3 slow", PS);
    regWrite(A_PWR, 16'h0000);
  endtask

  task automatic testAlias();
    regWrite(A_PWR, 16'hFEFF); // R6 bit8 clear, others ignored
    readCheck("R6 pwr clear", A_CLK, 16'h0000);
    regWrite(A_PWR, 16'h0100);
    readCheck("R6 pwr->clk", A_CLK, 16'h8000);
    readCheck("R10 pwr unused bits", A_PWR, 16'h0100);
    regWrite(A_CLK, 16'h4000); // R7 enable off, rate on
    readCheck("R7 clk->pwr", A_PWR, 16'h0000);
    readCheck("R7 clk read", A_CLK, 16'h4000);
    regWrite(A_CLK, 16'h0000);
    readCheck("R7 clk clear", A_CLK, 16'h0000);
  endtask

  task automatic testFast();
    regWrite(A_CLK, 16'hC000);
    expectPeriod("R4 fast", PF);
    // R5: count high cycles across several periods
    begin
      int high = 0;
      int pulses = 0;
      logic prev = tick;
      for (int i = 0; i < PF * 4; i++) begin
        @(posedge clk); @(negedge clk);
        if (tick) high++;
        if (tick && !prev) pulses++;
        prev = tick;
      end
      check("R5 high cycles equal pulses", 16'(high), 16'(pulses));
      check("R5 pulse count", 16'(pulses), 16'd4);
    end
    regWrite(A_CLK, 16'h0000);
    idleNoTick("R2 disabled after fast", PF * 3);
  endtask

  task automatic testDisableMid();
    regWrite(A_CLK, 16'h8000);
    for (int i = 0; i < PS / 2; i++) begin @(posedge clk); @(negedge clk); end
    regWrite(A_PWR, 16'h0000);
    idleNoTick("R8 off mid period", 5);
    regWrite(A_PWR, 16'h0100);
    expectPeriod("R8 restart after re-enable", PS);
    regWrite(A_PWR, 16'h0000);
  endtask

  task automatic testRateChange();
    regWrite(A_CLK, 16'h8000);
    for (int i = 0; i < PS / 2; i++) begin @(posedge clk); @(negedge clk); end
    regWrite(A_CLK, 16'hC000);
    expectPeriod("R9 slow->fast restart", PF);
    regWrite(A_CLK, 16'h0000);
    // same-rate rewrite mid period keeps schedule
    regWrite(A_CLK, 16'h8000);
    begin
      int firstAt = 0;
      for (int i = 1; i <= PS + 1; i++) begin
        if (i == 11) begin
          regWrEn = 1'b1; regAddr = A_CLK; regWrData = 16'h8000;
        end
        @(posedge clk); @(negedge clk);
        regWrEn = 1'b0; regAddr = 8'h00; regWrData = 16'h0;
        if (tick && firstAt == 0) firstAt = i;
      end
      check("R9 same-rate keeps count", 16'(firstAt), 16'(PS));
    end
    regWrite(A_CLK, 16'h0000);
  endtask

  task automatic testOtherAddr();
    regWrite(8'h11, 16'hFFFF);
    readCheck("R10 other write no effect", A_CLK, 16'h0000);
    regWrite(A_CLK, 16'hC000);
    readCheck("R10 other read zero", 8'h29, 16'h0000);
    regWrite(8'h27, 16'h0000);
    readCheck("R10 enable kept", A_PWR, 16'h0100);
    regWrite(A_CLK, 16'h0000);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testSlow();
    testAlias();
    testFast();
    testDisableMid();
    testRateChange();
    testOtherAddr();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule